// File: doc/BRIEF.md
# Nearest Clock Divider Search Engine

The engine turns a requested output frequency into the setting of a clock generator whose output is one of two fixed sources (288 MHz or 336 MHz) divided by an odd pre-divider and then by a power of two. After a start strobe it walks through every legal combination and keeps the one whose rounded result lies closest to the request. It then returns the control byte for the chosen clock target and the frequency that setting really produces.

There are three targets. The pixel and video targets run their generator at twice the output rate, so the search aims at twice the request and halves the result. The pixel target may also use a divide-by-5 pre-divider. A selector value that names no target ends the job at once with an error flag. Every candidate is evaluated by a shared iterative divider, and the achieved frequency comes from one more pass through that divider.

Top module: `clk_pick_top`

## Requirements
- R1: Selector encoding: `tgt_i` 0 = pixel, 1 = video, 2 = memory, 3 = invalid. The sources tried are 288 MHz and 336 MHz. The pre-dividers tried are 1 and 3, plus 5 for the pixel target only. Shifts 0 to 7 are tried for every source and pre-divider.
- R2: The candidate value is (2*src + d) / (2*d), with d = prediv << shift and integer division. The winner is the candidate with the smallest absolute difference from the search target.
- R3: Candidates are visited with the source as the outer loop (288 MHz first), then the pre-divider (ascending), then the shift (ascending). A candidate replaces the best only if its difference is strictly smaller, so on a tie the earlier candidate wins.
- R4: For pixel and video the search target is 2*`req_i`, and the reported frequency is halved with truncation. For memory the target is `req_i` unchanged.
- R5: Pixel byte layout: bits [2:0] shift, bit 3 set for pre-divider 3, bit 4 set for pre-divider 5, bit 5 set for the 336 MHz source, bits 7:6 zero.
- R6: Video and memory byte layout: bits [2:0] shift, bit 3 set for pre-divider 3, bit 4 set for the 336 MHz source, bits 7:5 zero.
- R7: `freq_o` is src / d with truncating division (halved as in R4), never the rounded candidate value.
- R8: A start with `tgt_i` = 3 while idle raises `done_o` on the following clock edge, with `err_o` = 1, `freq_o` = 0 and `code_o` = 0. A valid job ends with `err_o` = 0.
- R9: `done_o` is a single-cycle pulse. `code_o`, `freq_o` and `err_o` change only in a cycle where `done_o` is high. A start while a job is running is ignored.
- R10: After reset `done_o`, `err_o`, `code_o` and `freq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| tgt_i | input | 2 | Clock target selector |
| req_i | input | 32 | Requested frequency in Hz |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Invalid selector flag |
| code_o | output | 8 | Encoded clock control byte |
| freq_o | output | 32 | Achieved frequency in Hz |

## Verification
The assertions check on every cycle that the done pulse lasts one cycle, that the outputs stay put between pulses, that an invalid selector finishes on the next edge with zeroed results, and that the byte never shows bits outside the layout of its target. Whether the search picks the right candidate can only be shown by the bench's scenarios: exact hits, a request exactly halfway between two settings, requests outside the reachable range, a pixel request that needs divide-by-5, the same rate asked of the video target, and a start issued in the middle of a running search. Each result is compared with an exhaustive behavioural search.

// File: rtl/clk_pick_pkg.sv
package clk_pick_pkg;
  typedef enum logic [1:0] {
    TGT_PIX = 2'd0,
    TGT_VID = 2'd1,
    TGT_MEM = 2'd2,
    TGT_BAD = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FIN_LAUNCH,
    ST_FIN_WAIT
  } st_e;

  localparam int unsigned SRC_LO_HZ = 288_000_000;
  localparam int unsigned SRC_HI_HZ = 336_000_000;
endpackage

// File: rtl/clk_div_iter.sv
module clk_div_iter #(
  parameter int unsigned DW = 30,
  parameter int unsigned VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] q_q;
  logic [VW:0]   r_q;
  logic [VW-1:0] d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [VW:0]   r_sh;
  logic          ge;

  always_comb begin
    r_sh = {r_q[VW-1:0], q_q[DW-1]};
    ge   = r_sh >= {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= dividend_i;
        r_q   <= '0;
        d_q   <= divisor_i;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        r_q   <= ge ? (r_sh - {1'b0, d_q}) : r_sh;
        q_q   <= {q_q[DW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
endmodule

// File: rtl/clk_cand_walk.sv
module clk_cand_walk #(
  parameter int unsigned N_SRC   = 2,
  parameter int unsigned N_ODD   = 3,
  parameter int unsigned N_SHIFT = 8,
  localparam int unsigned SI_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned OI_W = (N_ODD > 1) ? $clog2(N_ODD) : 1,
  localparam int unsigned SH_W = (N_SHIFT > 1) ? $clog2(N_SHIFT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic [OI_W-1:0] last_odd_i,
  output logic [SI_W-1:0] src_o,
  output logic [OI_W-1:0] odd_o,
  output logic [SH_W-1:0] sh_o,
  output logic            last_o
);
  localparam logic [SH_W-1:0] SH_LAST  = SH_W'(N_SHIFT - 1);
  localparam logic [SI_W-1:0] SRC_LAST = SI_W'(N_SRC - 1);

  logic [SI_W-1:0] src_q;
  logic [OI_W-1:0] odd_q;
  logic [SH_W-1:0] sh_q;

  // shift is innermost, source outermost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      odd_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      src_q <= '0;
      odd_q <= '0;
      sh_q  <= '0;
    end else if (step_i) begin
      if (sh_q != SH_LAST) begin
        sh_q <= sh_q + 1'b1;
      end else begin
        sh_q <= '0;
        if (odd_q != last_odd_i) begin
          odd_q <= odd_q + 1'b1;
        end else begin
          odd_q <= '0;
          src_q <= src_q + 1'b1;
        end
      end
    end
  end

  assign src_o  = src_q;
  assign odd_o  = odd_q;
  assign sh_o   = sh_q;
  assign last_o = (src_q == SRC_LAST) && (odd_q == last_odd_i) && (sh_q == SH_LAST);
endmodule

// File: rtl/clk_pick_top.sv
module clk_pick_top
  import clk_pick_pkg::*;
#(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned N_ODD   = 3,
  parameter int unsigned N_SHIFT = 8,
  parameter int unsigned SRC_LO  = SRC_LO_HZ,
  parameter int unsigned SRC_HI  = SRC_HI_HZ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        tgt_i,
  input  logic [FREQ_W-1:0] req_i,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        code_o,
  output logic [FREQ_W-1:0] freq_o
);
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned OI_W    = (N_ODD > 1) ? $clog2(N_ODD) : 1;
  localparam int unsigned SH_W    = (N_SHIFT > 1) ? $clog2(N_SHIFT) : 1;
  localparam int unsigned ODD_MAX = 2 * N_ODD - 1;
  localparam int unsigned D_MAX   = ODD_MAX << (N_SHIFT - 1);
  localparam int unsigned NUM_W   = $clog2(2 * SRC_HI + D_MAX + 1);
  localparam int unsigned DV_W    = $clog2(2 * D_MAX + 1);
  localparam int unsigned TW      = FREQ_W + 1;

  st_e             state_q;
  tgt_e            tgt_q;
  logic [TW-1:0]   target_q;
  logic [OI_W-1:0] last_odd_q;
  logic [TW-1:0]   best_diff_q;
  logic            best_src_q;
  logic [OI_W-1:0] best_odd_q;
  logic [SH_W-1:0] best_sh_q;
  logic            done_q, err_q;
  logic [7:0]      code_q;
  logic [FREQ_W-1:0] freq_q;

  logic            w_src;
  logic [OI_W-1:0] w_odd;
  logic [SH_W-1:0] w_sh;
  logic            w_last, w_clear, w_step;

  logic              fin;
  logic              sel_src;
  logic [OI_W-1:0]   sel_odd;
  logic [SH_W-1:0]   sel_sh;
  logic [DV_W-1:0]   d_v;
  logic [NUM_W-1:0]  src_v;
  logic [NUM_W-1:0]  dvd;
  logic [DV_W-1:0]   dvs;
  logic              dv_start, dv_done;
  logic [NUM_W-1:0]  quot;
  logic [TW-1:0]     cand, diff;
  logic              busy;
  logic              accept;

  clk_cand_walk #(
    .N_SRC  (N_SRC),
    .N_ODD  (N_ODD),
    .N_SHIFT(N_SHIFT)
  ) i_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (w_clear),
    .step_i    (w_step),
    .last_odd_i(last_odd_q),
    .src_o     (w_src),
    .odd_o     (w_odd),
    .sh_o      (w_sh),
    .last_o    (w_last)
  );

  clk_div_iter #(
    .DW(NUM_W),
    .VW(DV_W)
  ) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dv_start),
    .dividend_i(dvd),
    .divisor_i (dvs),
    .done_o    (dv_done),
    .quot_o    (quot)
  );

  function automatic logic [7:0] enc_code(tgt_e t, logic s, logic [OI_W-1:0] o,
                                          logic [SH_W-1:0] sh);
    logic [7:0] b;
    b = '0;
    b[SH_W-1:0] = sh;
    b[3] = (o == OI_W'(1));
    if (t == TGT_PIX) begin
      b[4] = (o == OI_W'(2));
      b[5] = s;
    end else begin
      b[4] = s;
    end
    return b;
  endfunction

  always_comb begin
    busy    = state_q != ST_IDLE;
    accept  = (state_q == ST_IDLE) && start_i;
    fin     = state_q == ST_FIN_LAUNCH;
    sel_src = fin ? best_src_q : w_src;
    sel_odd = fin ? best_odd_q : w_odd;
    sel_sh  = fin ? best_sh_q  : w_sh;
    d_v     = DV_W'({sel_odd, 1'b1}) << sel_sh;
    src_v   = sel_src ? NUM_W'(SRC_HI) : NUM_W'(SRC_LO);
    // search pass: rounded src/d; final pass: truncated src/d
    dvd      = fin ? src_v : ((src_v << 1) + NUM_W'(d_v));
    dvs      = fin ? d_v : (d_v << 1);
    dv_start = (state_q == ST_LAUNCH) || fin;
    cand     = TW'(quot);
    diff     = (cand > target_q) ? (cand - target_q) : (target_q - cand);
    w_clear  = accept;
    w_step   = (state_q == ST_WAIT) && dv_done && !w_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tgt_q       <= TGT_MEM;
      target_q    <= '0;
      last_odd_q  <= '0;
      best_diff_q <= '0;
      best_src_q  <= 1'b0;
      best_odd_q  <= '0;
      best_sh_q   <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= '0;
      freq_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (tgt_e'(tgt_i) == TGT_BAD) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              code_q <= '0;
              freq_q <= '0;
            end else begin
              tgt_q       <= tgt_e'(tgt_i);
              target_q    <= (tgt_e'(tgt_i) == TGT_MEM) ? {1'b0, req_i} : {req_i, 1'b0};
              last_odd_q  <= (tgt_e'(tgt_i) == TGT_PIX) ? OI_W'(N_ODD - 1) : OI_W'(1);
              best_diff_q <= '1;
              state_q     <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (dv_done) begin
            if (diff < best_diff_q) begin
              best_diff_q <= diff;
              best_src_q  <= w_src;
              best_odd_q  <= w_odd;
              best_sh_q   <= w_sh;
            end
            state_q <= w_last ? ST_FIN_LAUNCH : ST_LAUNCH;
          end
        end
        ST_FIN_LAUNCH: state_q <= ST_FIN_WAIT;
        ST_FIN_WAIT: begin
          if (dv_done) begin
            done_q  <= 1'b1;
            err_q   <= 1'b0;
            code_q  <= enc_code(tgt_q, best_src_q, best_odd_q, best_sh_q);
            freq_q  <= (tgt_q == TGT_MEM) ? FREQ_W'(quot) : FREQ_W'(quot >> 1);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign code_o = code_q;
  assign freq_o = freq_q;
endmodule

// File: rtl/clk_pick_chk.sv
module clk_pick_chk #(
  parameter int unsigned FREQ_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        tgt_i,
  input logic              done_o,
  input logic              err_o,
  input logic [7:0]        code_o,
  input logic [FREQ_W-1:0] freq_o,
  input logic              busy,
  input logic [1:0]        tgt_q
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  hold_freq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(freq_o) && $stable(code_o) && $stable(err_o)));

  // R8
  bad_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && tgt_i == 2'd3) |=> (done_o && err_o));

  // R8
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (freq_o == '0 && code_o == 8'h00));

  // R5
  pix_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && tgt_q == 2'd0) |-> (code_o[7:6] == 2'b00 && !(code_o[3] && code_o[4])));

  // R6
  other_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && tgt_q != 2'd0) |-> (code_o[7:5] == 3'b000));

  // R7
  freq_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (freq_o != '0));
endmodule

bind clk_pick_top clk_pick_chk #(.FREQ_W(FREQ_W)) i_clk_pick_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .tgt_i  (tgt_i),
  .done_o (done_o),
  .err_o  (err_o),
  .code_o (code_o),
  .freq_o (freq_o),
  .busy   (busy),
  .tgt_q  (tgt_q)
);

// File: tb/test_clk_pick_top.sv
module test_clk_pick_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n, start;
  logic [1:0]  tgt;
  logic [31:0] req;
  logic        done, err;
  logic [7:0]  code;
  logic [31:0] freq;

  int n_chk, n_fail, cyc;
  bit pending, hold_on;
  logic [7:0]  exp_code, held_code;
  logic [31:0] exp_freq, held_freq;
  logic        exp_err, held_err;
  int          start_cyc;
  string       exp_tag;

  clk_pick_top i_clk_pick_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tgt_i(tgt), .req_i(req),
    .done_o(done), .err_o(err), .code_o(code), .freq_o(freq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // exhaustive behavioural search over the requirement's candidate space
  function automatic void ref_pick(int t, longint r, output logic [7:0] b,
                                   output logic [31:0] f);
    longint goal, best, c, dv, df, src;
    int bs, bo, bh, nodd;
    goal = (t == 2) ? r : 2 * r;
    nodd = (t == 0) ? 3 : 2;
    best = 64'h7fff_ffff_ffff_ffff;
    bs = 0; bo = 0; bh = 0;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < nodd; o++)
        for (int h = 0; h < 8; h++) begin
          src = (s == 1) ? 336000000 : 288000000;
          dv  = longint'(2 * o + 1) << h;
          c   = (2 * src + dv) / (2 * dv);
          df  = (c > goal) ? c - goal : goal - c;
          if (df < best) begin
            best = df; bs = s; bo = o; bh = h;
          end
        end
    src = (bs == 1) ? 336000000 : 288000000;
    c = src / (longint'(2 * bo + 1) << bh);
    if (t != 2) c = c / 2;
    f = c[31:0];
    b = 8'(bh);
    b[3] = (bo == 1);
    if (t == 0) begin b[4] = (bo == 2); b[5] = bs[0]; end
    else b[4] = bs[0];
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && hold_on) begin
      if (done) begin
        check(pending, {exp_tag, " unexpected done"}, 1, 0);
        if (pending) begin
          check(code == exp_code, {exp_tag, " code"}, code, exp_code);
          check(freq == exp_freq, {exp_tag, " freq"}, freq, exp_freq);
          check(err == exp_err, {exp_tag, " err"}, err, exp_err);
          if (exp_err) check(cyc - start_cyc == 1, "R8 latency", cyc - start_cyc, 1);
          held_code = exp_code; held_freq = exp_freq; held_err = exp_err;
          pending = 1'b0;
        end
      end else begin
        check(code == held_code && freq == held_freq && err == held_err,
              "R9 hold", freq, held_freq);
      end
    end
  end

  task automatic run(int t, longint r, string tag, bit poke = 1'b0);
    @(negedge clk);
    exp_tag = tag;
    if (t == 3) begin
      exp_code = 8'h00; exp_freq = 32'd0; exp_err = 1'b1;
    end else begin
      ref_pick(t, r, exp_code, exp_freq);
      exp_err = 1'b0;
    end
    start = 1'b1; tgt = 2'(t); req = r[31:0];
    start_cyc = cyc;
    pending = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; tgt = 2'd3; req = 32'd5;
      @(negedge clk);
      start = 1'b1; tgt = 2'd2; req = 32'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (pending) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    pending = 1'b0; hold_on = 1'b0;
    held_code = '0; held_freq = '0; held_err = 1'b0;
    start = 1'b0; tgt = '0; req = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(done == 1'b0 && err == 1'b0, "R10 flags", {done, err}, 0);
    check(code == 8'h00, "R10 code", code, 0);
    check(freq == 32'd0, "R10 freq", freq, 0);
    hold_on = 1'b1;

    run(2, 72000000, "R2 mem 72M");
    run(2, 144000000, "R6 mem 144M");
    run(2, 336000000, "R6 mem 336M src flag");
    run(0, 25175000, "R5 pix 25.175M");
    run(0, 28800000, "R5 pix div5");
    run(1, 28800000, "R1 vid no div5");
    run(1, 65000000, "R4 vid 65M");
    run(1, 168000000, "R4 vid 168M");
    run(2, 312000000, "R3 tie earliest");
    run(2, 0, "R3 zero request");
    run(2, 64'd4294967295, "R2 above range");
    run(0, 1000000, "R7 pix 1M");
    run(2, 10000000, "R7 mem 10M");
    run(3, 1234, "R8 invalid");
    run(0, 40000000, "R9 start while busy", 1'b1);
    run(3, 0, "R8 invalid again");

    hold_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule